// File: doc/BRIEF.md
# Clock-Synchronized Serial Byte Transmitter

This block sends bytes one bit at a time over a clocked serial link, least significant bit first. A host writes a byte into a one-entry holding register. The byte is copied into the shift register on the first falling edge of the serial clock for that byte, and at that moment the holding register counts as empty again. On the same edge a one-cycle interrupt pulse asks the host for the next byte, so that byte can be written while the current one shifts out. The data output changes only on falling edges, so the receiver samples it on rising edges.

The `slave_mode` input picks one of two roles. In master mode (`slave_mode` = 0) the block makes the serial clock by dividing the system clock. The clock idles high and each phase lasts `half_period` system cycles. A byte starts only when the peer's active-low ready input is low and the holding register has data, at whichever of the two comes last. In slave mode (`slave_mode` = 1) the serial clock comes from the peer. It passes through a two-flop synchronizer with falling- and rising-edge detection. The block pulls its active-low ready output low while it has a byte to send. The master-mode ready input must be synchronous to `clk`. The slave-mode serial clock must be slower than a quarter of `clk`.

The controller has three states. IDLE waits for a byte. SHIFT sends bits 0 to 7. TAIL holds the link after bit 7 until the next falling edge. The transitions are:
- start: IDLE to SHIFT. In master mode it fires when data and ready are both present. In slave mode it fires on an incoming falling edge while data is present. The byte is loaded here.
- step: SHIFT to SHIFT on each falling edge before bit 7.
- finish: SHIFT to TAIL on the rising edge of bit 7. In master mode it is always taken. In slave mode it is taken only when the holding register is full.
- drop: SHIFT to IDLE on the rising edge of bit 7, in slave mode, with an empty holding register.
- chain: TAIL to SHIFT on the next falling edge when a byte can be loaded. The byte is loaded here.
- stop: TAIL to IDLE on that falling edge when no byte can be loaded.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset: `sclk_out` = 1, `sout` = 1, `buf_empty` = 1, `tx_busy` = 0, `irq_empty` = 0, `rdy_n_out` = 1.
- R2: A cycle with `wr_en` = 1 stores `wr_data` in the holding register, and `buf_empty` reads 0 from the next cycle on. If a write and a load happen in the same cycle, the write wins the flag and the load takes the older byte.
- R3: In master mode, while the holding register is empty or `rdy_n_in` = 1, the block stays in IDLE, `tx_busy` = 0 and `sclk_out` stays 1. A byte starts at the first clock edge at which both conditions hold.
- R4: At the load edge, `buf_empty` becomes 1 and `irq_empty` pulses high for exactly one cycle.
- R5: Bits leave LSB first. Bit 0 appears on the load edge, and each later falling edge presents the next bit. In master mode `sout` stays stable while `sclk_out` is high.
- R6: In master mode, `sclk_out` falls on the start edge. After that, every phase of `sclk_out` lasts `half_period` cycles (`half_period` ≥ 1). `sclk_out` is 1 whenever the block is idle.
- R7: `tx_busy` = 1 exactly while the state is SHIFT or TAIL.
- R8: If the next byte was written before the bit-7 rising edge (and, in master mode, `rdy_n_in` is low at the following falling edge), it starts on that falling edge with no idle gap and without `tx_busy` dropping.
- R9: In master mode, if the holding register is empty or `rdy_n_in` = 1 at the falling edge after bit 7, the clock stays high and the block returns to IDLE. A buffered byte waits until ready returns.
- R10: In slave mode, `rdy_n_out` = 0 while the holding register is full or `tx_busy` = 1, and 1 otherwise. In master mode it is 1.
- R11: In slave mode, a falling edge on `sclk_in` takes effect (load or shift) at the third `clk` edge after it is sampled.
- R12: In slave mode, `sclk_in` edges received while idle with an empty holding register change no output.
- R13: A byte written during a transfer does not disturb the bits of the byte being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 0 = drive the serial clock, 1 = follow `sclk_in` |
| half_period | input | DIV_W | System cycles per serial clock phase in master mode (≥ 1) |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| rdy_n_in | input | 1 | Peer ready, active low (master mode) |
| sclk_in | input | 1 | Serial clock from the peer (slave mode) |
| sclk_out | output | 1 | Serial clock to the peer (master mode), idles high |
| rdy_n_out | output | 1 | Ready to the peer, active low (slave mode) |
| sout | output | 1 | Serial data |
| buf_empty | output | 1 | Holding register empty |
| tx_busy | output | 1 | Byte transfer in progress |
| irq_empty | output | 1 | One-cycle pulse when the holding register empties |

## Verification
Every result is due at a fixed cycle after its cause:
- A write shows on `buf_empty` one edge later.
- A master start (data plus ready) moves `sclk_out`, `sout`, `tx_busy` and `irq_empty` on the very next edge. Each later phase boundary comes `half_period` edges after the last one.
- In slave mode, an `sclk_in` edge shows on the outputs at the third `clk` edge after it is driven.

The bench holds a behavioural model stepped on the same edges. It compares every output one time unit after each edge, so a result that arrives one cycle early or late is a mismatch. Directed checks sample at those same offsets. A receiver captures `sout` on each serial rising edge and checks whole bytes.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } sst_state_e;
endpackage

// File: rtl/sst_mclk.sv
module sst_mclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             run,
    input  logic             fall_en,
    input  logic [DIV_W-1:0] half_period,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_due
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick     = (cnt_q == half_period - 1'b1);
    assign rise_stb = run && tick && !sclk;
    assign fall_due = run && tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk  <= 1'b1;
            cnt_q <= '0;
        end else if (kick) begin
            sclk  <= 1'b0;
            cnt_q <= '0;
        end else if (!run) begin
            sclk  <= 1'b1;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            if (!sclk)
                sclk <= 1'b1;
            else if (fall_en)
                sclk <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: a high phase ends low only when the controller lets it
    p_fall_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_due && !fall_en && !kick) |=> sclk);
endmodule

// File: rtl/sst_sync.sv
module sst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic fall_stb,
    output logic rise_stb
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '1;
        else
            chain_q <= {chain_q[STAGES-1:0], sclk_in};
    end

    assign fall_stb = chain_q[STAGES] && !chain_q[STAGES-1];
    assign rise_stb = !chain_q[STAGES] && chain_q[STAGES-1];

    // R11: an edge is reported for a single cycle only
    p_fall_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
endmodule

// File: rtl/sst_holdreg.sv
module sst_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else if (wr_en) begin
            data <= wr_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R2: a write always leaves the register full
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              sout,
    output logic              last
);
    localparam int IW = $clog2(DATA_W);

    logic [DATA_W-1:0] sreg_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
            sout   <= 1'b1;
        end else if (load) begin
            sreg_q <= din;
            idx_q  <= '0;
            sout   <= din[0];
        end else if (shift) begin
            sreg_q <= {1'b0, sreg_q[DATA_W-1:1]};
            idx_q  <= idx_q + 1'b1;
            sout   <= sreg_q[1];
        end
    end

    assign last = (idx_q == IW'(DATA_W - 1));

    // R5: no shift is requested past the final bit
    p_no_overshift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !last);
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rdy_n_in,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              rdy_n_out,
    output logic              sout,
    output logic              buf_empty,
    output logic              tx_busy,
    output logic              irq_empty
);
    sst_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_data;
    logic              buf_full;
    logic              load, shift, kick, fall_en, run;
    logic              m_rise, m_fall_due, s_fall, s_rise;
    logic              fall_ev, rise_ev, can_load, last;

    assign run      = !slave_mode && (state_q != ST_IDLE);
    assign fall_ev  = slave_mode ? s_fall : m_fall_due;
    assign rise_ev  = slave_mode ? s_rise : m_rise;
    assign can_load = buf_full && (slave_mode || !rdy_n_in);

    sst_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(load), .data(hold_data), .full(buf_full)
    );

    sst_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(hold_data), .sout(sout), .last(last)
    );

    sst_mclk #(.DIV_W(DIV_W)) u_mclk (
        .clk(clk), .rst_n(rst_n), .kick(kick), .run(run), .fall_en(fall_en),
        .half_period(half_period), .sclk(sclk_out),
        .rise_stb(m_rise), .fall_due(m_fall_due)
    );

    sst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
        .fall_stb(s_fall), .rise_stb(s_rise)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: start, step, finish, drop, chain, stop
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        kick    = 1'b0;
        fall_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (slave_mode) begin
                    if (s_fall && can_load) begin
                        load    = 1'b1;
                        state_d = ST_SHIFT;
                    end
                end else if (can_load) begin
                    kick    = 1'b1;
                    load    = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (fall_ev && !last) begin
                    shift   = 1'b1;
                    fall_en = 1'b1;
                end
                if (rise_ev && last)
                    state_d = (slave_mode && !buf_full) ? ST_IDLE : ST_TAIL;
            end
            ST_TAIL: begin
                if (fall_ev) begin
                    if (can_load) begin
                        load    = 1'b1;
                        fall_en = 1'b1;
                        state_d = ST_SHIFT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // interrupt pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_empty <= 1'b0;
        else
            irq_empty <= load;
    end

    // outputs
    always_comb begin
        tx_busy   = (state_q != ST_IDLE);
        buf_empty = !buf_full;
        rdy_n_out = !(slave_mode && (buf_full || state_q != ST_IDLE));
    end

    // R4: the request pulse lasts one cycle
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |=> !irq_empty);

    // R4: the pulse coincides with an empty register unless a write raced it
    p_irq_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> (buf_empty || $past(wr_en)));

    // R6: master clock rests high when idle
    p_idle_clk_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !tx_busy) |-> sclk_out);

    // R3: no start while the peer is not ready
    p_hold_for_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !tx_busy && rdy_n_in) |=> (slave_mode || !tx_busy));

    // R5: data steady during a master high phase
    p_sout_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && sclk_out && $past(sclk_out)) |-> $stable(sout));
endmodule

// File: tb/sync_ser_tx_test.sv
`timescale 1ns/100ps
module sync_ser_tx_test;
    localparam int DW = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic [VW-1:0] half_period = 8'd2;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rdy_n_in = 1'b1;
    logic          sclk_in = 1'b1;
    logic          sclk_out, rdy_n_out, sout, buf_empty, tx_busy, irq_empty;

    sync_ser_tx #(.DATA_W(DW), .DIV_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .half_period(half_period), .wr_en(wr_en), .wr_data(wr_data),
        .rdy_n_in(rdy_n_in), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .rdy_n_out(rdy_n_out), .sout(sout), .buf_empty(buf_empty),
        .tx_busy(tx_busy), .irq_empty(irq_empty)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // behavioural reference: a bit queue stands for the shift register
    int       m_st;
    bit       m_full;
    logic [7:0] m_buf;
    bit       m_q[$];
    logic     m_sout, m_irq, m_sclk;
    int       m_cnt;
    logic     y1, y2, y3;

    always @(posedge clk) begin
        bit fall, rise, sf, sr, ld, sh, can;
        logic [7:0] snap;
        if (!rst_n) begin
            m_st = 0; m_full = 0; m_buf = 0; m_q.delete();
            m_sout = 1; m_irq = 0; m_sclk = 1; m_cnt = 0;
            y1 = 1; y2 = 1; y3 = 1;
        end else begin
            sf = y3 && !y2;
            sr = !y3 && y2;
            y3 = y2; y2 = y1; y1 = sclk_in;
            ld = 0; sh = 0; fall = 0; rise = 0;
            snap = m_buf;
            can = m_full && (slave_mode || !rdy_n_in);
            if (slave_mode || m_st == 0) begin
                m_cnt = 0; m_sclk = 1;
            end else if (m_cnt == int'(half_period) - 1) begin
                m_cnt = 0;
                if (m_sclk) fall = 1;
                else begin rise = 1; m_sclk = 1; end
            end else begin
                m_cnt++;
            end
            if (slave_mode) begin fall = sf; rise = sr; end
            case (m_st)
                0: if (slave_mode ? (fall && can) : can) begin ld = 1; m_st = 1; end
                1: begin
                    if (fall && m_q.size() > 0) sh = 1;
                    if (rise && m_q.size() == 0) m_st = (slave_mode && !m_full) ? 0 : 2;
                end
                default: if (fall) begin
                    if (can) begin ld = 1; m_st = 1; end
                    else m_st = 0;
                end
            endcase
            if (ld) begin
                m_q.delete();
                for (int i = 0; i < 8; i++) m_q.push_back(snap[i]);
                m_sout = m_q.pop_front();
                if (!slave_mode) m_sclk = 0;
            end
            if (sh) begin
                m_sout = m_q.pop_front();
                if (!slave_mode) m_sclk = 0;
            end
            m_irq = ld;
            if (wr_en) begin m_buf = wr_data; m_full = 1; end
            else if (ld) m_full = 0;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R6 sclk_out", sclk_out, m_sclk);
            chk(slave_mode ? "R11 sout" : "R5 sout", sout, m_sout);
            chk("R2 buf_empty", buf_empty, !m_full);
            chk("R4 irq_empty", irq_empty, m_irq);
            chk("R7 tx_busy", tx_busy, m_st != 0);
            chk("R10 rdy_n_out", rdy_n_out, !(slave_mode && (m_full || m_st != 0)));
        end
    end

    // serial receiver on the rising edges of whichever clock is in use
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] rx_sh = '0;
    int   rx_n = 0;
    logic prev_eff = 1'b1;
    always @(posedge clk) begin
        logic eff;
        #2;
        eff = slave_mode ? sclk_in : sclk_out;
        if (rst_n && eff && !prev_eff && tx_busy) begin
            rx_sh = {sout, rx_sh[7:1]};
            rx_n++;
            if (rx_n == 8) begin rx_q.push_back(rx_sh); rx_n = 0; end
        end
        prev_eff = eff;
    end

    int busy_drops = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (prev_busy && !tx_busy) busy_drops++;
        prev_busy = tx_busy;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            finish_up();
        end
    end

    task automatic put(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        tx_q.push_back(d);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (tx_busy) @(negedge clk);
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!irq_empty) @(negedge clk);
    endtask

    task automatic check_rx(string tag);
        chk({tag, " byte count"}, rx_q.size(), tx_q.size());
        while (rx_q.size() > 0 && tx_q.size() > 0)
            chk({tag, " byte"}, rx_q.pop_front(), tx_q.pop_front());
        rx_q.delete(); tx_q.delete(); rx_n = 0;
    endtask

    task automatic slave_clocks(int n, int h);
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b0;
            repeat (h) @(negedge clk);
            sclk_in = 1'b1;
            repeat (h) @(negedge clk);
        end
    endtask

    initial begin
        logic hold_sout;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 sclk_out", sclk_out, 1); chk("R1 sout", sout, 1);
        chk("R1 buf_empty", buf_empty, 1); chk("R1 tx_busy", tx_busy, 0);
        chk("R1 irq_empty", irq_empty, 0); chk("R1 rdy_n_out", rdy_n_out, 1);

        // master: data first, ready later
        put(8'hA5);
        repeat (10) @(negedge clk);
        chk("R3 busy while not ready", tx_busy, 0);
        chk("R3 clock idle", sclk_out, 1);
        chk("R2 buffer full", buf_empty, 0);
        rdy_n_in = 1'b0;
        @(posedge clk); #1;
        chk("R3 start busy", tx_busy, 1);
        chk("R6 first fall", sclk_out, 0);
        chk("R4 irq", irq_empty, 1);
        chk("R4 empty", buf_empty, 1);
        chk("R5 bit0", sout, 1);
        wait_idle();
        check_rx("R5");

        // master: ready first, data later
        put(8'h3C);
        wait_idle();
        check_rx("R3");

        // back-to-back at the fastest clock
        half_period = 8'd1;
        busy_drops = 0;
        put(8'h11);
        wait_irq(); put(8'h22);
        wait_irq(); put(8'hC3);
        wait_idle();
        chk("R8 single busy drop", busy_drops, 1);
        check_rx("R13");

        // ready withdrawn before the end of a byte
        half_period = 8'd3;
        put(8'h44);
        wait_irq(); put(8'h55);
        @(negedge clk); rdy_n_in = 1'b1;
        wait_idle();
        chk("R9 idle", tx_busy, 0);
        chk("R9 byte kept", buf_empty, 0);
        repeat (12) @(negedge clk);
        chk("R9 still waiting", tx_busy, 0);
        chk("R9 clock high", sclk_out, 1);
        rdy_n_in = 1'b0;
        wait_idle();
        check_rx("R9");

        // slave mode
        @(negedge clk); slave_mode = 1'b1;
        @(negedge clk);
        chk("R10 not ready when empty", rdy_n_out, 1);
        hold_sout = sout;
        slave_clocks(3, 4);
        repeat (4) @(negedge clk);
        chk("R12 busy", tx_busy, 0);
        chk("R12 empty", buf_empty, 1);
        chk("R12 sout", sout, hold_sout);
        chk("R12 irq", irq_empty, 0);
        put(8'hC6);
        chk("R10 ready low", rdy_n_out, 0);
        sclk_in = 1'b0;
        @(posedge clk); #1; chk("R11 edge 1", tx_busy, 0);
        @(posedge clk); #1; chk("R11 edge 2", tx_busy, 0);
        @(posedge clk); #1; chk("R11 edge 3", tx_busy, 1);
        chk("R11 bit0", sout, 0);
        @(negedge clk);
        sclk_in = 1'b1;
        put(8'h5A);
        repeat (2) @(negedge clk);
        slave_clocks(7, 4);
        slave_clocks(8, 4);
        repeat (6) @(negedge clk);
        chk("R10 released", rdy_n_out, 1);
        chk("R7 slave idle", tx_busy, 0);
        check_rx("R8 slave");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule